// File: doc/BRIEF.md
# Serial Host Data Buffers and Interrupt Logic

This block holds the transmit and receive queues of a serial-bus host controller, together with its error tracking and its two interrupt lines. Software-side writes of the transmit data port fill the transmit queue, and the serial engine drains it one word at a time. The engine fills the receive queue, and software-side reads of the receive data port drain it. A write to a full transmit queue and a push into a full receive queue are both dropped. A read of an empty receive queue returns zero. Each of these misuses sets a sticky error bit.

Each queue has a watermark that comes from a control register, and crossing it raises an event. Error bits and event conditions are masked by their own enables before they reach an interrupt state register. That register has write-one-to-clear, a test-inject port and a per-line enable. Separate control pulses empty the transmit queue, empty the receive queue, or send a one-cycle reset to the serial engine.

Top module: `shost_buf_irq`

## Requirements
- R1: A transmit write is accepted when the transmit queue holds fewer than DEPTH words. Accepted words appear on `tx_head_data` in write order, with `tx_head_valid` high. Each `tx_pop` on a non-empty queue advances to the next word. `tx_level` reports the word count, which never exceeds DEPTH.
- R2: A transmit write while `tx_level` equals DEPTH is discarded: the level and the queued words are unchanged. From the next cycle, `err_status` bit 0 (transmit overflow) is set.
- R3: `rx_rd_data` shows the oldest received word, and an `rx_rd_en` cycle removes it. With the receive queue empty, `rx_rd_data` is zero and a read sets `err_status` bit 1 (underflow). A `rx_push` into a full receive queue is dropped and sets `err_status` bit 2 (receive overflow).
- R4: Error status bits stay set until a cycle in which the matching `err_clr` bit is 1. Other bits are unaffected by that clear. If a bit is set and cleared in the same cycle, it stays set.
- R5: Interrupt state bit 0 (error) is set one cycle after the count of error bits that are both set and enabled by `err_en` goes from none to at least one. This includes the case where an already-set error becomes enabled. A set error whose enable is 0 never sets the bit.
- R6: Interrupt state bit 1 (event) is set in every cycle after a cycle in which an enabled event holds. Event 0 is `rx_level >= rx_wm`, enabled by `evt_en[0]`. Event 1 is `tx_level < tx_wm`, enabled by `evt_en[1]`.
- R7: A 1 on a bit of `intr_test` sets that interrupt state bit on the next edge. A 1 on a bit of `intr_clr` clears it. If a bit is set and cleared in the same cycle, it stays set.
- R8: `irq_error` is high exactly when interrupt state bit 0 and `intr_en[0]` are both 1. `irq_event` is high exactly when interrupt state bit 1 and `intr_en[1]` are both 1.
- R9: After a `tx_clr` cycle, the transmit queue is empty: `tx_head_valid` is low, earlier words are never presented again, and the next write becomes the head. After a `rx_clr` cycle, `rx_level` is 0 and `rx_rd_data` reads zero.
- R10: `eng_rst` is high in the cycle after each cycle with `eng_clr` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Write strobe of the transmit data port |
| tx_wr_data | input | DW | Transmit data word |
| tx_pop | input | 1 | Serial engine consumes the transmit head |
| tx_head_valid | output | 1 | Transmit queue not empty |
| tx_head_data | output | DW | Oldest transmit word |
| tx_level | output | $clog2(DEPTH)+1 | Transmit word count |
| rx_push | input | 1 | Serial engine delivers a received word |
| rx_push_data | input | DW | Received word |
| rx_rd_en | input | 1 | Read strobe of the receive data port |
| rx_rd_data | output | DW | Oldest received word, zero when empty |
| rx_level | output | $clog2(DEPTH)+1 | Receive word count |
| tx_wm | input | $clog2(DEPTH)+1 | Transmit watermark |
| rx_wm | input | $clog2(DEPTH)+1 | Receive watermark |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue |
| eng_clr | input | 1 | Request a serial engine reset |
| eng_rst | output | 1 | Reset pulse to the serial engine |
| err_en | input | 3 | Error enables |
| err_clr | input | 3 | Write-one-to-clear for error status |
| err_status | output | 3 | Sticky error status |
| evt_en | input | 2 | Event enables |
| intr_en | input | 2 | Interrupt line enables |
| intr_test | input | 2 | Interrupt test inject |
| intr_clr | input | 2 | Write-one-to-clear for interrupt state |
| intr_state | output | 2 | Interrupt state |
| irq_error | output | 1 | Error interrupt line |
| irq_event | output | 1 | Event interrupt line |

## Verification
The assertions assume that every strobe and clear input is a clean, synchronous level sampled at the rising edge. They also assume that the watermark inputs stay within 0 to DEPTH. The transmit overflow property assumes no pop in the same cycle as the dropped write. The stimulus keeps to these assumptions: it drives every input only one time unit after an edge, holds the engine pop low during overflow writes, and keeps the watermarks between 0 and 2.

// File: rtl/shost_buf_irq.sv
module shost_buf_irq #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr_en,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_pop,
  output logic          tx_head_valid,
  output logic [DW-1:0] tx_head_data,
  output logic [LW-1:0] tx_level,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_rd_en,
  output logic [DW-1:0] rx_rd_data,
  output logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_wm,
  input  logic [LW-1:0] rx_wm,
  input  logic          tx_clr,
  input  logic          rx_clr,
  input  logic          eng_clr,
  output logic          eng_rst,
  input  logic [2:0]    err_en,
  input  logic [2:0]    err_clr,
  output logic [2:0]    err_status,
  input  logic [1:0]    evt_en,
  input  logic [1:0]    intr_en,
  input  logic [1:0]    intr_test,
  input  logic [1:0]    intr_clr,
  output logic [1:0]    intr_state,
  output logic          irq_error,
  output logic          irq_event
);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [2:0]    err_q;
  logic          err_any_q;
  logic [1:0]    st_q;

  wire tx_full  = (tx_cnt == LW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == LW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);

  wire tx_push_ok = tx_wr_en & ~tx_full;
  wire tx_pop_ok  = tx_pop & ~tx_empty;
  wire rx_push_ok = rx_push & ~rx_full;
  wire rx_pop_ok  = rx_rd_en & ~rx_empty;

  wire tx_ovf = tx_wr_en & tx_full & ~tx_clr;
  wire rx_ovf = rx_push & rx_full & ~rx_clr;
  wire rx_unf = rx_rd_en & rx_empty & ~rx_clr;

  wire       err_any = |(err_q & err_en);
  wire [1:0] evt     = {tx_cnt < tx_wm, rx_cnt >= rx_wm};
  wire       evt_any = |(evt & evt_en);
  wire [1:0] st_set  = intr_test | {evt_any, err_any & ~err_any_q};

  assign tx_head_valid = ~tx_empty;
  assign tx_head_data  = tx_mem[tx_rp];
  assign tx_level      = tx_cnt;
  assign rx_rd_data    = rx_empty ? '0 : rx_mem[rx_rp];
  assign rx_level      = rx_cnt;
  assign err_status    = err_q;
  assign intr_state    = st_q;
  assign irq_error     = st_q[0] & intr_en[0];
  assign irq_event     = st_q[1] & intr_en[1];

  always_ff @(posedge clk) begin
    if (tx_push_ok && !tx_clr) tx_mem[tx_wp] <= tx_wr_data;
    if (rx_push_ok && !rx_clr) rx_mem[rx_wp] <= rx_push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push_ok) tx_wp <= nxt(tx_wp);
      if (tx_pop_ok)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + LW'(tx_push_ok) - LW'(tx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push_ok) rx_wp <= nxt(rx_wp);
      if (rx_pop_ok)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + LW'(rx_push_ok) - LW'(rx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= '0;
      err_any_q <= 1'b0;
      st_q      <= '0;
      eng_rst   <= 1'b0;
    end else begin
      err_q     <= (err_q & ~err_clr) | {rx_ovf, rx_unf, tx_ovf};
      err_any_q <= err_any;
      st_q      <= (st_q & ~intr_clr) | st_set;
      eng_rst   <= eng_clr;
    end
  end

  assert_tx_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= LW'(DEPTH) && rx_cnt <= LW'(DEPTH));

  assert_tx_overflow_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && tx_full && !tx_clr && !tx_pop) |=> ($stable(tx_cnt) && err_q[0]));

  assert_rx_underflow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en && rx_empty && !rx_clr) |=> err_q[1]);

  assert_err_intr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[0]) |-> $past(intr_test[0] || err_any));

  assert_test_inject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intr_test[1] |=> st_q[1]);

  assert_rx_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_cnt == '0 && rx_rd_data == '0));

endmodule

// File: tb/shost_buf_irq_tb.sv
module shost_buf_irq_tb;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_wr_en = 0, tx_pop = 0, rx_push = 0, rx_rd_en = 0;
  logic [DW-1:0] tx_wr_data = '0, rx_push_data = '0;
  logic tx_head_valid, eng_rst, irq_error, irq_event;
  logic [DW-1:0] tx_head_data, rx_rd_data;
  logic [LW-1:0] tx_level, rx_level;
  logic [LW-1:0] tx_wm = '0, rx_wm = '0;
  logic tx_clr = 0, rx_clr = 0, eng_clr = 0;
  logic [2:0] err_en = '0, err_clr = '0, err_status;
  logic [1:0] evt_en = '0, intr_en = '0, intr_test = '0, intr_clr = '0, intr_state;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  shost_buf_irq #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_pop(tx_pop),
    .tx_head_valid(tx_head_valid), .tx_head_data(tx_head_data), .tx_level(tx_level),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .rx_level(rx_level),
    .tx_wm(tx_wm), .rx_wm(rx_wm), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .eng_clr(eng_clr), .eng_rst(eng_rst),
    .err_en(err_en), .err_clr(err_clr), .err_status(err_status),
    .evt_en(evt_en), .intr_en(intr_en), .intr_test(intr_test), .intr_clr(intr_clr),
    .intr_state(intr_state), .irq_error(irq_error), .irq_event(irq_event));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wipe();
    err_en = '0; evt_en = '0; intr_en = '0;
    tx_clr = 1; rx_clr = 1; err_clr = 3'b111; intr_clr = 2'b11;
    step();
    tx_clr = 0; rx_clr = 0; err_clr = '0; intr_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1", "tx_level at reset", tx_level, 0);
    chk("R1", "tx_head_valid at reset", tx_head_valid, 0);
    chk("R3", "rx_rd_data at reset", rx_rd_data, 0);
    chk("R4", "err_status at reset", err_status, 0);
    chk("R7", "intr_state at reset", intr_state, 0);
    chk("R10", "eng_rst at reset", eng_rst, 0);
  endtask

  task automatic t_tx_order();
    wipe();
    for (int i = 0; i < 3; i++) begin
      tx_wr_en = 1; tx_wr_data = DW'(8'h30 + i); step();
    end
    tx_wr_en = 0;
    chk("R1", "tx_level after 3 writes", tx_level, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R1", "tx head order", tx_head_data, 8'h30 + i);
      tx_pop = 1; step(); tx_pop = 0;
    end
    chk("R1", "tx empty after pops", tx_head_valid, 0);
  endtask

  task automatic t_tx_overflow();
    wipe();
    for (int i = 0; i < DEPTH; i++) begin
      tx_wr_en = 1; tx_wr_data = DW'(i + 1); step();
    end
    chk("R2", "no overflow flag while filling", err_status[0], 0);
    tx_wr_data = 8'hEE; step(); tx_wr_en = 0;
    chk("R2", "tx_level after dropped write", tx_level, DEPTH);
    chk("R2", "overflow flag", err_status[0], 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2", "queued word kept", tx_head_data, i + 1);
      tx_pop = 1; step(); tx_pop = 0;
    end
    chk("R2", "dropped word never queued", tx_head_valid, 0);
  endtask

  task automatic t_rx();
    wipe();
    for (int i = 0; i < 3; i++) begin
      rx_push = 1; rx_push_data = DW'(8'hA0 + i); step();
    end
    rx_push = 0;
    chk("R3", "rx_level", rx_level, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3", "rx read order", rx_rd_data, 8'hA0 + i);
      rx_rd_en = 1; step(); rx_rd_en = 0;
    end
    chk("R3", "empty read data", rx_rd_data, 0);
    chk("R3", "no underflow yet", err_status[1], 0);
    rx_rd_en = 1; step(); rx_rd_en = 0;
    chk("R3", "underflow flag", err_status[1], 1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_push = 1; rx_push_data = DW'(8'h50 + i); step();
    end
    rx_push = 0;
    chk("R3", "rx_level full", rx_level, DEPTH);
    chk("R3", "rx overflow flag", err_status[2], 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3", "rx kept word", rx_rd_data, 8'h50 + i);
      rx_rd_en = 1; step(); rx_rd_en = 0;
    end
    chk("R3", "rx empty after drain", rx_level, 0);
  endtask

  task automatic t_err_sticky();
    wipe();
    chk("R4", "cleared status", err_status, 0);
    rx_rd_en = 1; step(); rx_rd_en = 0;
    step();
    chk("R4", "sticky underflow", err_status, 3'b010);
    err_clr = 3'b001; step(); err_clr = '0;
    chk("R4", "other bit clear no effect", err_status, 3'b010);
    err_clr = 3'b010; step(); err_clr = '0;
    chk("R4", "bit cleared", err_status, 0);
    rx_rd_en = 1; err_clr = 3'b010; step(); rx_rd_en = 0; err_clr = '0;
    chk("R4", "set wins over clear", err_status, 3'b010);
  endtask

  task automatic t_err_irq();
    wipe();
    rx_rd_en = 1; step(); rx_rd_en = 0;
    step(); step();
    chk("R5", "disabled error no state", intr_state[0], 0);
    err_en = 3'b010; step();
    chk("R5", "enabling set error raises state", intr_state[0], 1);
    chk("R8", "pin low when line disabled", irq_error, 0);
    intr_en = 2'b01; #1;
    chk("R8", "pin high when state and enable", irq_error, 1);
    intr_clr = 2'b01; step(); intr_clr = '0;
    step();
    chk("R5", "no re-fire while error stays set", intr_state[0], 0);
    chk("R8", "pin low after clear", irq_error, 0);
  endtask

  task automatic t_events();
    wipe();
    rx_wm = 2; evt_en = 2'b01; intr_en = 2'b10;
    rx_push = 1; rx_push_data = 8'h11; step(); rx_push = 0;
    step();
    chk("R6", "rx below watermark", intr_state[1], 0);
    rx_push = 1; rx_push_data = 8'h12; step(); rx_push = 0;
    step();
    chk("R6", "rx at watermark", intr_state[1], 1);
    chk("R8", "event pin", irq_event, 1);
    evt_en = '0; intr_clr = 2'b10; step(); intr_clr = '0;
    chk("R6", "event cleared", intr_state[1], 0);
    tx_wm = 1; evt_en = 2'b10; step(); step();
    chk("R6", "tx below watermark", intr_state[1], 1);
    evt_en = '0; intr_clr = 2'b10; step(); intr_clr = '0;
    tx_wr_en = 1; tx_wr_data = 8'h01; step(); tx_wr_en = 0;
    evt_en = 2'b10; step(); step();
    chk("R6", "tx at watermark no event", intr_state[1], 0);
    evt_en = '0; tx_wm = '0; rx_wm = '0; intr_en = '0;
  endtask

  task automatic t_intr_test();
    wipe();
    intr_test = 2'b11; step(); intr_test = '0;
    chk("R7", "test inject both", intr_state, 2'b11);
    intr_clr = 2'b01; step(); intr_clr = '0;
    chk("R7", "w1c one bit", intr_state, 2'b10);
    intr_clr = 2'b10; intr_test = 2'b10; step(); intr_clr = '0; intr_test = '0;
    chk("R7", "set wins over clear", intr_state, 2'b10);
    intr_clr = 2'b11; step(); intr_clr = '0;
    chk("R7", "all cleared", intr_state, 0);
  endtask

  task automatic t_clears();
    wipe();
    for (int i = 0; i < 4; i++) begin
      tx_wr_en = 1; tx_wr_data = DW'(8'hC0 + i); step();
    end
    tx_wr_en = 0;
    tx_clr = 1; step(); tx_clr = 0;
    chk("R9", "tx level after clear", tx_level, 0);
    chk("R9", "tx head invalid after clear", tx_head_valid, 0);
    tx_wr_en = 1; tx_wr_data = 8'h5A; step(); tx_wr_en = 0;
    chk("R9", "new head after clear", tx_head_data, 8'h5A);
    tx_pop = 1; step(); tx_pop = 0;
    chk("R9", "old data never sent", tx_head_valid, 0);
    rx_push = 1; rx_push_data = 8'h77; step(); rx_push = 0;
    rx_clr = 1; step(); rx_clr = 0;
    chk("R9", "rx level after clear", rx_level, 0);
    chk("R9", "rx read zero after clear", rx_rd_data, 0);
  endtask

  task automatic t_engine();
    eng_clr = 1; step(); eng_clr = 0;
    chk("R10", "engine reset pulse", eng_rst, 1);
    step();
    chk("R10", "engine reset released", eng_rst, 0);
  endtask

  initial begin
    #20; @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_tx_order();
    t_tx_overflow();
    t_rx();
    t_err_sticky();
    t_err_irq();
    t_events();
    t_intr_test();
    t_clears();
    t_engine();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule